// File: doc/BRIEF.md
# Peak-Current-Mode Boost Gate Controller

This block drives the gate of the power switch in a fixed-frequency boost converter that uses peak-current-mode control. While enabled, it starts a new switching period at a fixed rate. The rate comes from the system clock through an integer divider whose ratio is set by the system and switching frequency parameters. At every period start the gate turns on. It turns off at the first of three events: the PWM comparator trips, the peak current limit is reached, or a hard maximum on-time expires. Once off, it stays off until the next period start.

The three comparator results arrive from the analog side as asynchronous levels. Each passes through a two-flop synchroniser. A short blanking window after turn-on masks the PWM and current-limit inputs, and this window already includes the synchroniser delay. The low-feedback comparator is qualified only after soft-start has ended. When it is qualified, it latches a boost fault that holds the gate off and is reported to the start-up sequencer. Dropping the enable clears the fault.

Top module: `cm_boost_pwm`

## Requirements
- R1: While enabled and free of fault, `cyc_start_o` pulses high for exactly one clock once every PERIOD clocks. PERIOD is SYS_CLK_KHZ / SW_FREQ_KHZ, which is 208 with the defaults.
- R2: The gate is never high for more than MAX_ON consecutive clocks, where MAX_ON = PERIOD * MAX_DUTY_PCT / 100 (176 by default). With no comparator activity the gate is high for exactly MAX_ON clocks per period, starting in the cycle where `cyc_start_o` is high.
- R3: Once the synchronised current-limit input ends a pulse, the gate stays low for the rest of that period, even if the input falls again at once. It turns on again only at the next period start.
- R4: Number the cycles of a period from 1, starting with the cycle where `cyc_start_o` is high. If the PWM trip input is high at the clock edge that ends cycle k, and the pulse is not blanked, the gate is low from cycle k+3 on. This gives an on-time of k+2 clocks.
- R5: While `en_i` is low, `gate_o` and `cyc_start_o` stay low. In the first cycle after `en_i` is sampled high, both `gate_o` and `cyc_start_o` are high.
- R6: A synchronised low-feedback indication seen while enabled and outside soft-start sets `fault_o` at the same edge that forces the gate low. The fault stays latched with no switching and no `cyc_start_o` until `en_i` is sampled low, which clears it.
- R7: The trip and current-limit inputs are ignored while the period cycle index is below BLANK_CLKS (6 by default). An input held high from cycle k therefore gives an on-time of max(k+2, BLANK_CLKS), capped at MAX_ON.
- R8: While `ss_active_i` is high, the low-feedback input has no effect: `fault_o` stays low and switching continues.
- R9: After reset, `gate_o`, `cyc_start_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable from the start-up sequencer |
| ss_active_i | input | 1 | Soft-start in progress |
| pwm_trip_i | input | 1 | Asynchronous PWM comparator result (sense ramp has crossed the error level) |
| ilim_i | input | 1 | Asynchronous peak current limit comparator result |
| fb_low_i | input | 1 | Asynchronous feedback-below-trip-level comparator result |
| gate_o | output | 1 | Switch gate drive |
| cyc_start_o | output | 1 | One-clock strobe at each period start |
| fault_o | output | 1 | Latched boost fault |

## Verification
The bench measures the on-time of every period and compares it with a bench function that models the synchroniser delay, the blanking floor and the duty cap. A design that miscounts the delay shows pulses one clock off. Leaky blanking lets a glitch in the first cycles cut the pulse short. A missing cap leaves the gate on through the whole period. A one-clock current-limit pulse after blanking checks that the pulse stays ended: a design that follows the input level would turn the gate back on. The fault sequence holds low feedback through soft-start, where a design that does not qualify the input would latch early. It then checks that the latched fault blocks all switching and strobes until the enable drops.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    // Comparator inputs carried together through the synchroniser
    typedef struct packed {
        logic fb_low;
        logic ilim;
        logic trip;
    } cmp_vec_t;

    localparam int unsigned CMP_W = $bits(cmp_vec_t);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_DONE = 2'd2
    } gate_phase_e;

    function automatic int unsigned period_from_rates(input int unsigned sys_khz,
                                                      input int unsigned sw_khz);
        return sys_khz / sw_khz;
    endfunction

    function automatic int unsigned on_limit(input int unsigned period,
                                             input int unsigned pct);
        return (period * pct) / 100;
    endfunction

endpackage

// File: rtl/cmb_sync.sv
module cmb_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/cmb_period_timer.sv
module cmb_period_timer #(
    parameter int unsigned PERIOD = 208,
    parameter int unsigned CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst || !en)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/cmb_fault_qual.sv
module cmb_fault_qual (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ss_active,
    input  logic fb_low,
    output logic fault,
    output logic kill
);
    logic fault_q;
    logic fault_set;

    assign fault_set = en && !ss_active && fb_low;

    always_ff @(posedge clk) begin
        if (rst || !en) fault_q <= 1'b0;
        else            fault_q <= fault_q | fault_set;
    end

    assign fault = fault_q;
    assign kill  = fault_q | fault_set;

    // R8
    ss_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ss_active && !fault) |=> !fault);
    // R6
    fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fault);
    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && en) |=> fault);
endmodule

// File: rtl/cmb_gate_ctrl.sv
module cmb_gate_ctrl
    import cmb_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned MAX_ON = 176,
    parameter int unsigned BLANK  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kill,
    input  logic [CNT_W-1:0] cnt,
    input  logic             trip,
    input  logic             ilim,
    output logic             gate,
    output logic             cyc_stb
);
    localparam logic [CNT_W-1:0] ON_CAP  = CNT_W'(MAX_ON);
    localparam logic [CNT_W-1:0] BLK_END = CNT_W'(BLANK);

    gate_phase_e phase_q, phase_d;
    logic        stb_q;
    logic        unblanked;
    logic        end_req;

    assign unblanked = (cnt >= BLK_END);
    assign end_req   = (unblanked && (trip || ilim)) || (cnt >= ON_CAP);

    always_comb begin
        phase_d = phase_q;
        if (!en || kill)                         phase_d = PH_IDLE;
        else if (cnt == '0)                      phase_d = PH_ON;
        else if (phase_q == PH_ON && end_req)    phase_d = PH_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            stb_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            stb_q   <= en && !kill && (cnt == '0);
        end
    end

    assign gate    = (phase_q == PH_ON);
    assign cyc_stb = stb_q;

    // Run length of the current on-time, kept for the duty check
    logic [CNT_W:0] on_len;
    always_ff @(posedge clk) begin
        if (rst || !gate) on_len <= '0;
        else              on_len <= on_len + 1'b1;
    end

    // R2
    max_on_chk: assert property (@(posedge clk) disable iff (rst)
        gate |-> (on_len < (CNT_W+1)'(MAX_ON)));
    // R5
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate && !cyc_stb));
    // R1
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> cyc_stb);
    // R3
    ilim_end_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && ilim && unblanked) |=> !gate);
    // R7
    blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate && en && !kill && !unblanked) |=> gate);
endmodule

// File: rtl/cm_boost_pwm.sv
module cm_boost_pwm
    import cmb_pkg::*;
#(
    parameter int unsigned SYS_CLK_KHZ  = 250000,
    parameter int unsigned SW_FREQ_KHZ  = 1200,
    parameter int unsigned MAX_DUTY_PCT = 85,
    parameter int unsigned BLANK_CLKS   = 6,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic ss_active_i,
    input  logic pwm_trip_i,
    input  logic ilim_i,
    input  logic fb_low_i,
    output logic gate_o,
    output logic cyc_start_o,
    output logic fault_o
);
    localparam int unsigned PERIOD = period_from_rates(SYS_CLK_KHZ, SW_FREQ_KHZ);
    localparam int unsigned MAX_ON = on_limit(PERIOD, MAX_DUTY_PCT);
    localparam int unsigned CNT_W  = $clog2(PERIOD);

    cmp_vec_t raw_cmp, sync_cmp;
    logic [CNT_W-1:0] cnt;
    logic kill;

    assign raw_cmp = '{fb_low: fb_low_i, ilim: ilim_i, trip: pwm_trip_i};

    cmb_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(raw_cmp), .q(sync_cmp)
    );

    cmb_period_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .en(en_i), .cnt(cnt)
    );

    cmb_fault_qual fault_i (
        .clk(clk), .rst(rst), .en(en_i), .ss_active(ss_active_i),
        .fb_low(sync_cmp.fb_low), .fault(fault_o), .kill(kill)
    );

    cmb_gate_ctrl #(.CNT_W(CNT_W), .MAX_ON(MAX_ON), .BLANK(BLANK_CLKS)) gate_i (
        .clk(clk), .rst(rst), .en(en_i), .kill(kill), .cnt(cnt),
        .trip(sync_cmp.trip), .ilim(sync_cmp.ilim),
        .gate(gate_o), .cyc_stb(cyc_start_o)
    );

    // R6
    fault_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !gate_o);
    // R6
    fault_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !cyc_start_o);
endmodule

// File: tb/cm_boost_pwm_tb_top.sv
`timescale 1ns/1ps
module cm_boost_pwm_tb_top;
    localparam int PERIOD = 250000 / 1200;
    localparam int MAX_ON = PERIOD * 85 / 100;
    localparam int BLANK  = 6;
    localparam int HOLD   = 10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, ss = 1'b0, trip = 1'b0, ilim = 1'b0, fbl = 1'b0;
    logic gate, stb, fault;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cm_boost_pwm dut_i (
        .clk(clk), .rst(rst), .en_i(en), .ss_active_i(ss),
        .pwm_trip_i(trip), .ilim_i(ilim), .fb_low_i(fbl),
        .gate_o(gate), .cyc_start_o(stb), .fault_o(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected end cycle caused by one input; 0 in t means no activity
    function automatic int end_of(input int t, input int len);
        int c;
        if (t == 0) return MAX_ON;
        c = (t + 2 > BLANK) ? t + 2 : BLANK;
        if (c > t + 1 + len) return MAX_ON;
        return (c < MAX_ON) ? c : MAX_ON;
    endfunction

    function automatic int exp_width(input int tt, input int tl, input int it, input int il);
        int a, b;
        a = end_of(tt, tl);
        b = end_of(it, il);
        return (a < b) ? a : b;
    endfunction

    // Entered at the negedge of period cycle 1 (cyc_start high)
    task automatic run_period(input int tt, input int tl, input int it, input int il,
                              input string req);
        int width = 0;
        bit fell = 1'b0;
        bit regrow = 1'b0;
        for (int k = 1; k < PERIOD; k++) begin
            if (k == tt) trip = 1'b1;
            if (tt != 0 && k == tt + tl) trip = 1'b0;
            if (k == it) ilim = 1'b1;
            if (it != 0 && k == it + il) ilim = 1'b0;
            if (gate) begin
                width++;
                if (fell) regrow = 1'b1;
            end else begin
                fell = 1'b1;
            end
            @(negedge clk);
        end
        trip = 1'b0;
        ilim = 1'b0;
        chk(!gate && !stb, "R1 cycle PERIOD idle", int'(gate) + int'(stb), 0);
        @(negedge clk);
        chk(stb && gate, "R1 next period start", int'(stb), 1);
        chk(!regrow, {req, " one pulse per period (R3)"}, int'(regrow), 0);
        chk(width == exp_width(tt, tl, it, il), {req, " on-time"}, width,
            exp_width(tt, tl, it, il));
    endtask

    initial begin
        int gcount, scount;
        void'($urandom(32'd4321));
        repeat (4) @(negedge clk);
        // R9
        chk(!gate && !stb && !fault, "R9 reset outputs", int'(gate) + int'(stb) + int'(fault), 0);
        rst = 1'b0;

        // R5: idle while disabled, comparators wiggling
        gcount = 0; scount = 0;
        for (int i = 0; i < 60; i++) begin
            trip = i[2]; ilim = i[3];
            @(negedge clk);
            gcount += int'(gate); scount += int'(stb);
        end
        trip = 1'b0; ilim = 1'b0;
        chk(gcount == 0, "R5 no gate while disabled", gcount, 0);
        chk(scount == 0, "R5 no strobe while disabled", scount, 0);

        ss = 1'b1;
        en = 1'b1;
        @(negedge clk);
        chk(gate && stb, "R5 first pulse after enable", int'(gate) + int'(stb), 2);

        run_period(0, 0, 0, 0, "R2 no trip");
        run_period(1, 1, 0, 0, "R7 glitch in blanking");
        run_period(0, 0, 2, 1, "R7 ilim glitch in blanking");
        run_period(3, HOLD, 0, 0, "R7 held from blanking");
        run_period(40, HOLD, 0, 0, "R4 trip");
        run_period(0, 0, 50, 1, "R3 one-clock ilim");
        run_period(100, HOLD, 60, HOLD, "R3 ilim before trip");
        run_period(174, HOLD, 0, 0, "R2 trip at cap");
        run_period(180, HOLD, 0, 0, "R2 trip after cap");

        // R8: low feedback during soft-start
        fbl = 1'b1;
        run_period(0, 0, 0, 0, "R8 switching during soft-start");
        chk(!fault, "R8 fault masked in soft-start", int'(fault), 0);
        fbl = 1'b0;

        // Random periods
        for (int n = 0; n < 40; n++) begin
            int tt, tl, it, il;
            tt = ($urandom % 3 == 0) ? 0 : 1 + ($urandom % 190);
            tl = ($urandom % 2 == 0) ? HOLD : 1 + ($urandom % 8);
            it = ($urandom % 2 == 0) ? 0 : 1 + ($urandom % 190);
            il = ($urandom % 2 == 0) ? HOLD : 1 + ($urandom % 8);
            run_period(tt, tl, it, il, "R4 random");
        end

        // R6: fault after soft-start
        fbl = 1'b1;
        repeat (5) @(negedge clk);
        chk(!fault, "R8 fault still masked", int'(fault), 0);
        ss = 1'b0;
        @(negedge clk);
        chk(fault == 1'b1, "R6 fault latched", int'(fault), 1);
        chk(!gate, "R6 gate forced off", int'(gate), 0);
        fbl = 1'b0;
        gcount = 0; scount = 0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            @(negedge clk);
            gcount += int'(gate); scount += int'(stb);
            if (!fault) gcount += 1000;
        end
        chk(gcount == 0, "R6 no switching while faulted", gcount, 0);
        chk(scount == 0, "R6 no strobe while faulted", scount, 0);
        en = 1'b0;
        @(negedge clk);
        chk(!fault, "R6 fault cleared by disable", int'(fault), 0);
        en = 1'b1;
        @(negedge clk);
        chk(gate && stb, "R5 restart after fault", int'(gate) + int'(stb), 2);
        run_period(0, 0, 0, 0, "R2 after restart");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule